// File: doc/BRIEF.md
# PCM DSP-mode serial shifter

This block is the serial data path of a PCM audio port that uses DSP framing. In each frame it sends one 16-bit sample, most significant bit first, on a serial output. In the same frame it assembles one 16-bit word from a serial input. The port is always the clock master. The clock generator next to the block supplies three things as single-cycle strobes in the system clock domain:

- a launch strobe for the bit-clock edge on which transmit data changes;
- a sample strobe for the opposite edge, on which receive data is captured;
- a frame-sync level that is qualified by the launch strobe.

Each direction has its own alignment input. When it is set, the most significant bit sits in the bit slot after the frame sync. When it is clear, the most significant bit shares the slot with the frame sync. Setting both inputs gives the "late" DSP framing and clearing both gives the "early" one. Mixed settings are also legal.

A sample source offers a transmit word with a valid flag. At a frame start the block takes the word and answers with an acknowledge in the same cycle. If no word is offered, the block sends a silent frame and raises an underrun strobe. Each received word is presented with a one-cycle valid strobe.

Top module: `pcm_dsp_shifter`

## Requirements
- R1: After reset, tx_sd, tx_underrun and rx_valid are 0 and rx_data is 16'h0000.
- R2: A frame starts on a cycle with bit_launch=1 and fsync=1. In that cycle tx_ack equals tx_valid, and tx_data is taken as the frame's sample when tx_valid=1.
- R3: If tx_valid=0 at a frame start, the frame carries only zeros and tx_underrun is 1 for exactly the following cycle.
- R4: tx_sd changes only in the cycle after a bit_launch strobe. The sample is sent MSB first, one bit per launch strobe.
- R5: With tx_late=1 at the frame start, the frame-sync slot (slot 0) carries 0 and sample bits 15..0 occupy slots 1..16. With tx_late=0, bits 15..0 occupy slots 0..15.
- R6: Every slot after the last sample bit carries 0 until the next frame start.
- R7: rx_sd is captured on bit_sample strobes. With rx_late=1, the capture in slot 0 is discarded and the MSB is taken in slot 1. With rx_late=0, the capture in slot 0 is the MSB.
- R8: In the cycle after the 16th kept capture, rx_data shows the assembled word (first capture in bit 15) and rx_valid is 1 for that one cycle only. rx_data is held at all other times.
- R9: A frame start before 16 bits have been kept discards the partial word, so no rx_valid results from it.
- R10: tx_late and rx_late are used only at the frame start. Changing them later in the frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_launch | input | 1 | Strobe for the bit-clock edge that launches transmit data |
| bit_sample | input | 1 | Strobe for the opposite bit-clock edge, used to capture receive data |
| fsync | input | 1 | Frame sync, qualified by bit_launch |
| tx_late | input | 1 | Transmit MSB one slot after the frame sync (1) or aligned with it (0) |
| rx_late | input | 1 | Receive MSB one slot after the frame sync (1) or aligned with it (0) |
| tx_valid | input | 1 | A transmit sample is offered |
| tx_data | input | 16 | Offered transmit sample |
| tx_ack | output | 1 | Sample taken at this frame start |
| tx_underrun | output | 1 | The previous cycle's frame start found no sample |
| tx_sd | output | 1 | Serial transmit data |
| rx_sd | input | 1 | Serial receive data |
| rx_valid | output | 1 | rx_data holds a newly completed word |
| rx_data | output | 16 | Last received word |

## Verification
A wrong bit counter or a skip flag left set shows up at the ports within one frame. The transmit line puts the word one slot early or late, or keeps driving past slot 16. In loopback, the received word comes out shifted by one position, and its rx_valid pulse appears one sample strobe away from the expected one. A stale alignment latch makes the late and early framings look identical. So every pairing of transmit and receive alignment is swept with walking-one and edge-value samples, and each expected word is derived arithmetically from the slot offsets. Partial frames and mid-frame changes to the alignment inputs reach the restart and latching state. That state would otherwise stay hidden until the next completed word.

// File: rtl/pcm_dsp_shifter.sv
module pcm_dsp_shifter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bit_launch,
  input  logic         bit_sample,
  input  logic         fsync,
  input  logic         tx_late,
  input  logic         rx_late,
  input  logic         tx_valid,
  input  logic [W-1:0] tx_data,
  output logic         tx_ack,
  output logic         tx_underrun,
  output logic         tx_sd,
  input  logic         rx_sd,
  output logic         rx_valid,
  output logic [W-1:0] rx_data
);
  localparam int CW = $clog2(W + 1);

  logic         frame_start;
  logic [W-1:0] tx_load;
  logic [W-1:0] tx_sh;
  logic [CW-1:0] tx_left;
  logic [W-1:0] rx_sh;
  logic [CW-1:0] rx_cnt;
  logic         rx_busy, rx_skip;

  assign frame_start = bit_launch & fsync;
  assign tx_ack      = frame_start & tx_valid;
  assign tx_load     = tx_valid ? tx_data : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_sd       <= 1'b0;
      tx_sh       <= '0;
      tx_left     <= '0;
      tx_underrun <= 1'b0;
    end else begin
      tx_underrun <= frame_start & ~tx_valid;
      if (frame_start) begin
        if (tx_late) begin
          tx_sd   <= 1'b0;
          tx_sh   <= tx_load;
          tx_left <= CW'(W);
        end else begin
          tx_sd   <= tx_load[W-1];
          tx_sh   <= {tx_load[W-2:0], 1'b0};
          tx_left <= CW'(W - 1);
        end
      end else if (bit_launch) begin
        if (tx_left != '0) begin
          tx_sd   <= tx_sh[W-1];
          tx_sh   <= {tx_sh[W-2:0], 1'b0};
          tx_left <= tx_left - 1'b1;
        end else begin
          tx_sd <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_sh    <= '0;
      rx_cnt   <= '0;
      rx_busy  <= 1'b0;
      rx_skip  <= 1'b0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (frame_start) begin
        rx_busy <= 1'b1;
        rx_skip <= rx_late;
        rx_cnt  <= '0;
      end else if (bit_sample && rx_busy) begin
        if (rx_skip) begin
          rx_skip <= 1'b0;
        end else begin
          rx_sh <= {rx_sh[W-2:0], rx_sd};
          if (rx_cnt == CW'(W - 1)) begin
            rx_data  <= {rx_sh[W-2:0], rx_sd};
            rx_valid <= 1'b1;
            rx_busy  <= 1'b0;
          end else begin
            rx_cnt <= rx_cnt + 1'b1;
          end
        end
      end
    end
  end

  a_r3_underrun_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !tx_valid) |=> tx_underrun);
  a_r4_tx_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_launch |=> $stable(tx_sd));
  a_r5_late_slot0_low: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && tx_late) |=> !tx_sd);
  a_r6_tail_low: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_launch && !fsync && tx_left == '0) |=> !tx_sd);
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  a_r8_data_held: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> $stable(rx_data));
  a_r9_restart_no_word: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !rx_valid);
  a_r2_ack_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_ack && tx_underrun && $past(frame_start)));
endmodule

// File: tb/pcm_dsp_shifter_tb_top.sv
module pcm_dsp_shifter_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_launch = 1'b0, bit_sample = 1'b0, fsync = 1'b0;
  logic tx_late = 1'b0, rx_late = 1'b0, tx_valid = 1'b0;
  logic [15:0] tx_data = '0;
  logic tx_ack, tx_underrun, tx_sd, rx_valid;
  logic [15:0] rx_data;
  logic rx_sd;

  int n_tests = 0, n_fail = 0, nvalid = 0;
  logic [15:0] last_rx = '0;

  always #2.5 clk = ~clk;
  assign rx_sd = tx_sd;

  pcm_dsp_shifter #(.W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .bit_launch(bit_launch), .bit_sample(bit_sample),
    .fsync(fsync), .tx_late(tx_late), .rx_late(rx_late), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_ack(tx_ack), .tx_underrun(tx_underrun), .tx_sd(tx_sd),
    .rx_sd(rx_sd), .rx_valid(rx_valid), .rx_data(rx_data));

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic poll();
    if (rx_valid) begin
      nvalid++;
      last_rx = rx_data;
    end
  endtask

  task automatic run_frame(input string req, input logic [15:0] smp, input bit vld,
                           input bit tl, input bit rl, input int nslots, input bit flip);
    logic [31:0] got_tx = '0, exp_tx = '0;
    logic [15:0] exp_rx = '0, prev_rx;
    bit want_word;
    prev_rx = last_rx;
    nvalid = 0;
    for (int s = 0; s < nslots; s++) begin
      @(negedge clk); poll();
      bit_launch = 1'b1; fsync = (s == 0);
      tx_late = (flip && s > 0) ? ~tl : tl;
      rx_late = (flip && s > 0) ? ~rl : rl;
      tx_valid = vld && (s == 0); tx_data = smp;
      if (s == 0) begin #1; chk({req, " R2 ack"}, {31'd0, tx_ack}, {31'd0, vld}); end
      @(negedge clk); poll();
      bit_launch = 1'b0; fsync = 1'b0; tx_valid = 1'b0;
      if (s == 0) chk({req, " R3 underrun"}, {31'd0, tx_underrun}, {31'd0, !vld});
      @(negedge clk); poll();
      bit_sample = 1'b1; got_tx[s] = tx_sd;
      @(negedge clk); poll();
      bit_sample = 1'b0;
    end
    @(negedge clk); poll();
    for (int s = 0; s < nslots; s++)
      if (vld && s >= int'(tl) && s < int'(tl) + 16) exp_tx[s] = smp[15 - (s - int'(tl))];
    chk({req, " R4 R5 R6 tx slots"}, got_tx, exp_tx);
    want_word = (nslots >= int'(rl) + 16);
    for (int k = 0; k < 16; k++) exp_rx[15 - k] = exp_tx[k + int'(rl)];
    chk({req, " R8 R9 valid count"}, nvalid, {31'd0, want_word});
    if (want_word) chk({req, " R7 rx word"}, {16'd0, last_rx}, {16'd0, exp_rx});
    else chk({req, " R8 rx_data held"}, {16'd0, rx_data}, {16'd0, prev_rx});
  endtask

  task automatic run_all();
    logic [15:0] pats [4] = '{16'hFFFF, 16'h8001, 16'hA5C3, 16'h0000};
    repeat (3) @(negedge clk);
    chk("R1 tx_sd", {31'd0, tx_sd}, 32'd0);
    chk("R1 underrun", {31'd0, tx_underrun}, 32'd0);
    chk("R1 rx_valid", {31'd0, rx_valid}, 32'd0);
    chk("R1 rx_data", {16'd0, rx_data}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int c = 0; c < 4; c++) begin
      for (int i = 0; i < 16; i++)
        run_frame("R5 walk", 16'(1 << i), 1'b1, c[0], c[1], 18, 1'b0);
      for (int p = 0; p < 4; p++)
        run_frame("R7 pattern", pats[p], 1'b1, c[0], c[1], 18, 1'b0);
      run_frame("R3 silent", 16'hBEEF, 1'b0, c[0], c[1], 18, 1'b0);
      run_frame("R9 partial", 16'h1234, 1'b1, c[0], c[1], 6, 1'b0);
      run_frame("R9 after partial", 16'h5A5A, 1'b1, c[0], c[1], 18, 1'b0);
      run_frame("R10 flip", 16'hC3E1, 1'b1, c[0], c[1], 18, 1'b1);
      run_frame("R6 long", 16'h7FFE, 1'b1, c[0], c[1], 24, 1'b0);
    end
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule